// File: doc/BRIEF.md
# Mode-Selected Phase Slope Limiter

This block sits between a clock loop filter and a numerically controlled oscillator. Its job is to bound how fast the output phase may move. Every clock cycle it takes one signed phase step request in picoseconds and returns the step the oscillator may actually apply. The returned step is either the request unchanged or a trimmed version of it.

A two-bit filter-mode select picks one of four slope budgets. Each budget is a largest allowed net phase excursion within a fixed observation window. The block keeps a running signed sum of the steps it has granted in the current window. It trims any request that would carry the magnitude of that sum past the budget. Windows are counted in sample ticks, derived from a tick-rate parameter. A change of mode restarts the window.

Top module: `slope_limiter`

## Requirements
- R1: Mode select 2'b00 (1.5 Hz loop) allows 41000 ps of net movement per short window, and 2'b11 (6 Hz loop) allows 50000 ps per short window. A short window lasts floor(TICK_HZ*1326/1000000) ticks, with a minimum of 1.
- R2: Mode select 2'b01 (0.1 Hz loop) allows 885000 ps per long window, and 2'b10 (12 Hz loop) allows 1200000000 ps per long window. A long window lasts TICK_HZ ticks.
- R3: A request passes unchanged when the window sum plus the request stays within plus or minus the budget.
- R4: A request that would push the sum above +budget is reduced to budget minus the sum. One that would push it below -budget is reduced to -budget minus the sum. A reduced step keeps the request's sign or becomes zero.
- R5: clamp_on is 1 exactly in those cycles where step_out differs from step_req.
- R6: The sample taken in the last tick of a window is still limited against that window. The next tick starts a new window with a zero sum.
- R7: A sample that arrives with a mode select different from the previous cycle's opens a fresh window under the new mode: zero sum, first tick.
- R8: After synchronous active-low reset, the window sum is 0, the window position is the first tick, and the remembered mode is 2'b00.
- R9: The magnitude of the window sum never exceeds the budget of the mode it accrued under.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one step per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Filter mode select, encoded as in R1 and R2 |
| step_req | input | STEP_W | Signed requested phase step, ps |
| step_out | output | STEP_W | Signed limited phase step, ps |
| clamp_on | output | 1 | High when step_out differs from step_req |

## Verification
Several properties are checked on every cycle: the window sum stays inside its budget, a trimmed step never grows or flips sign, an untrimmed step equals the request, the sum clears after the last tick of a window, and a mode change restarts the window. Some behaviour can only be shown by the bench's scenarios. These are the exact trimmed values, the window lengths derived from the tick rate, and the behaviour of the 0.1 Hz and 12 Hz budgets over full long windows. Another is that a reversal of direction earns back allowance. The bench checks all of these against a reference model built from the requirements.

// File: rtl/slope_lim_pkg.sv
// Package: shared mode encoding and the constant slope budgets.
// Assumes budgets fit a 32-bit signed accumulator.
package slope_lim_pkg;

    typedef enum logic [1:0] {
        FM_MID    = 2'b00,   // 1.5 Hz loop
        FM_NARROW = 2'b01,   // 0.1 Hz loop
        FM_WIDE   = 2'b10,   // 12 Hz loop
        FM_FAST   = 2'b11    // 6 Hz loop
    } fmode_e;

    localparam longint SHORT_WIN_US = 1326;
    localparam longint LONG_WIN_US  = 1000000;

    // Largest net excursion, in ps, allowed within one window of the mode.
    function automatic longint budget_ps(input fmode_e m);
        case (m)
            FM_MID:    return 41000;
            FM_NARROW: return 885000;
            FM_WIDE:   return 1200000000;
            default:   return 50000;
        endcase
    endfunction

    // True when the mode is observed over the one-second window.
    function automatic bit uses_long_window(input fmode_e m);
        return (m == FM_NARROW) || (m == FM_WIDE);
    endfunction

endpackage

// File: rtl/slope_mode_table.sv
// Module: maps the mode select to its budget and its last window tick.
// Assumes WIN_SHORT and WIN_LONG are at least 1 and fit CNT_W bits.
module slope_mode_table
    import slope_lim_pkg::*;
#(
    parameter int     ACC_W     = 32,
    parameter int     CNT_W     = 13,
    parameter longint WIN_SHORT = 10,
    parameter longint WIN_LONG  = 8000
) (
    input  fmode_e             mode,
    output logic [ACC_W-1:0]   budget,
    output logic [CNT_W-1:0]   win_last
);

    logic [ACC_W-1:0] budget_tbl [4];
    logic [CNT_W-1:0] last_tbl   [4];

    // One constant row per mode.
    for (genvar g = 0; g < 4; g++) begin : g_row
        assign budget_tbl[g] = ACC_W'(budget_ps(fmode_e'(g)));
        assign last_tbl[g]   = uses_long_window(fmode_e'(g)) ? CNT_W'(WIN_LONG - 1)
                                                              : CNT_W'(WIN_SHORT - 1);
    end

    // Select the row of the active mode.
    always_comb begin
        budget   = budget_tbl[mode];
        win_last = last_tbl[mode];
    end

endmodule

// File: rtl/slope_window.sv
// Module: window tick counter and signed running sum of granted steps.
// A mode differing from the stored one makes the current sample the first
// tick of a fresh window. Assumes |sum| stays within ACC_W signed range.
module slope_window
    import slope_lim_pkg::*;
#(
    parameter int STEP_W = 24,
    parameter int ACC_W  = 32,
    parameter int CNT_W  = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  fmode_e                   mode,
    input  logic [CNT_W-1:0]         win_last,
    input  logic signed [STEP_W-1:0] step_granted,
    output logic signed [ACC_W-1:0]  acc_eff
);

    logic signed [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0]        cnt_q;
    fmode_e                  sel_q;
    logic                    fresh;
    logic [CNT_W-1:0]        cnt_eff;
    logic signed [ACC_W-1:0] step_x;

    // View of the window as seen by the current sample.
    always_comb begin
        fresh   = (mode != sel_q);
        acc_eff = fresh ? '0 : acc_q;
        cnt_eff = fresh ? '0 : cnt_q;
        step_x  = ACC_W'(step_granted);
    end

    // Advance the window; clear after its last tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
            sel_q <= FM_MID;
        end else begin
            sel_q <= mode;
            if (cnt_eff == win_last) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else begin
                acc_q <= acc_eff + step_x;
                cnt_q <= cnt_eff + 1'b1;
            end
        end
    end

endmodule

// File: rtl/slope_clamp.sv
// Module: trims the requested step to the allowance left in the window.
// Assumes |acc_eff| <= budget and budget < 2**(ACC_W-1).
module slope_clamp #(
    parameter int STEP_W = 24,
    parameter int ACC_W  = 32
) (
    input  logic signed [ACC_W-1:0]  acc_eff,
    input  logic [ACC_W-1:0]         budget,
    input  logic signed [STEP_W-1:0] step_req,
    output logic signed [STEP_W-1:0] step_lim,
    output logic                     clamped
);

    logic signed [ACC_W:0] req_x, acc_x, hi, lo, sum, lim;

    // Compare the prospective sum with both budget rails.
    always_comb begin
        req_x = (ACC_W+1)'(step_req);
        acc_x = (ACC_W+1)'(acc_eff);
        hi    = $signed({1'b0, budget});
        lo    = -hi;
        sum   = acc_x + req_x;
        if (sum > hi)
            lim = hi - acc_x;
        else if (sum < lo)
            lim = lo - acc_x;
        else
            lim = req_x;
        step_lim = STEP_W'(lim);
        clamped  = (step_lim != step_req);
    end

endmodule

// File: rtl/slope_limiter.sv
// Module: top of the mode-selected phase slope limiter.
// One signed step per clock; the output is combinational from the request
// and the window state. Assumes STEP_W < ACC_W.
module slope_limiter
    import slope_lim_pkg::*;
#(
    parameter int     STEP_W  = 24,
    parameter longint TICK_HZ = 8000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               mode_sel,
    input  logic signed [STEP_W-1:0] step_req,
    output logic signed [STEP_W-1:0] step_out,
    output logic                     clamp_on
);

    localparam int     ACC_W      = 32;
    localparam longint WIN_SHORT_RAW = (TICK_HZ * SHORT_WIN_US) / 1000000;
    localparam longint WIN_SHORT  = (WIN_SHORT_RAW < 1) ? 1 : WIN_SHORT_RAW;
    localparam longint WIN_LONG   = (TICK_HZ < 1) ? 1 : TICK_HZ;
    localparam int     CNT_W      = $clog2(WIN_LONG + 1);

    fmode_e                  mode;
    logic [ACC_W-1:0]        budget;
    logic [CNT_W-1:0]        win_last;
    logic signed [ACC_W-1:0] acc_eff;

    // Decode the select into the package enum.
    always_comb mode = fmode_e'(mode_sel);

    slope_mode_table #(
        .ACC_W(ACC_W), .CNT_W(CNT_W), .WIN_SHORT(WIN_SHORT), .WIN_LONG(WIN_LONG)
    ) u_tbl (
        .mode(mode), .budget(budget), .win_last(win_last)
    );

    slope_window #(
        .STEP_W(STEP_W), .ACC_W(ACC_W), .CNT_W(CNT_W)
    ) u_win (
        .clk(clk), .rst_n(rst_n), .mode(mode), .win_last(win_last),
        .step_granted(step_out), .acc_eff(acc_eff)
    );

    slope_clamp #(
        .STEP_W(STEP_W), .ACC_W(ACC_W)
    ) u_clamp (
        .acc_eff(acc_eff), .budget(budget), .step_req(step_req),
        .step_lim(step_out), .clamped(clamp_on)
    );

endmodule

// File: rtl/slope_limiter_chk.sv
// Module: property checker bound into slope_limiter.
// Observes the ports plus the window registers and the budget table output.
module slope_limiter_chk #(
    parameter int STEP_W = 24,
    parameter int ACC_W  = 32,
    parameter int CNT_W  = 13
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               mode_sel,
    input logic signed [STEP_W-1:0] step_req,
    input logic signed [STEP_W-1:0] step_out,
    input logic                     clamp_on,
    input logic signed [ACC_W-1:0]  acc_q,
    input logic [CNT_W-1:0]         cnt_q,
    input logic [1:0]               sel_q,
    input logic [ACC_W-1:0]         budget,
    input logic [CNT_W-1:0]         win_last
);

    logic signed [ACC_W:0] acc_w, bud_w, req_w, out_w, req_abs, out_abs;
    logic                  same_mode;

    // Widened copies for sign-safe comparisons.
    always_comb begin
        acc_w     = (ACC_W+1)'(acc_q);
        bud_w     = $signed({1'b0, budget});
        req_w     = (ACC_W+1)'(step_req);
        out_w     = (ACC_W+1)'(step_out);
        req_abs   = (req_w < 0) ? -req_w : req_w;
        out_abs   = (out_w < 0) ? -out_w : out_w;
        same_mode = (mode_sel == sel_q);
    end

    p_within_budget_r9: assert property (@(posedge clk) disable iff (!rst_n)
        same_mode |-> (acc_w <= bud_w && acc_w >= -bud_w));

    p_sign_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_on |-> (out_abs < req_abs &&
                      (step_out == 0 || (step_out[STEP_W-1] == step_req[STEP_W-1]))));

    p_passthrough_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clamp_on |-> (step_out == step_req));

    p_wrap_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (same_mode && cnt_q == win_last) |=> (acc_q == 0 && cnt_q == 0));

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        same_mode |-> (cnt_q <= win_last));

    p_fresh_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !same_mode |=> (sel_q == $past(mode_sel) && cnt_q <= 1));

endmodule

bind slope_limiter slope_limiter_chk #(
    .STEP_W(STEP_W), .ACC_W(ACC_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .step_req(step_req),
    .step_out(step_out), .clamp_on(clamp_on),
    .acc_q(u_win.acc_q), .cnt_q(u_win.cnt_q), .sel_q(u_win.sel_q),
    .budget(budget), .win_last(win_last)
);

// File: tb/slope_limiter_test.sv
// Bench: directed corners plus seeded random steps, compared with a
// reference model written from the requirements.
module slope_limiter_test;

    localparam int     STEP_W  = 24;
    localparam longint TICK_HZ = 8000;
    localparam longint WSHORT  = ((TICK_HZ * 1326) / 1000000 < 1) ? 1 : (TICK_HZ * 1326) / 1000000;
    localparam longint WLONG   = TICK_HZ;
    localparam longint SMAX    = (64'sd1 <<< (STEP_W - 1)) - 1;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [1:0]               mode_sel = 2'b00;
    logic signed [STEP_W-1:0] step_req = '0;
    logic signed [STEP_W-1:0] step_out;
    logic                     clamp_on;

    int  n_checks = 0;
    int  n_err    = 0;
    bit  done     = 0;

    longint     m_acc = 0;
    longint     m_cnt = 0;
    logic [1:0] m_sel = 2'b00;

    always #5 clk = ~clk;

    slope_limiter #(.STEP_W(STEP_W), .TICK_HZ(TICK_HZ)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .step_req(step_req), .step_out(step_out), .clamp_on(clamp_on)
    );

    function automatic longint budget_of(input logic [1:0] s);
        case (s)
            2'b00:   return 41000;
            2'b01:   return 885000;
            2'b10:   return 1200000000;
            default: return 50000;
        endcase
    endfunction

    function automatic longint window_of(input logic [1:0] s);
        return (s == 2'b01 || s == 2'b10) ? WLONG : WSHORT;
    endfunction

    function automatic longint limit_of(input longint acc, input longint req, input longint b);
        if (acc + req > b)  return b - acc;
        if (acc + req < -b) return -b - acc;
        return req;
    endfunction

    task automatic check(input string tag, input longint got, input longint exp);
        n_checks++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // Drive one sample at the falling edge, check it, then step the model.
    task automatic apply(input logic [1:0] sel, input longint req, input string tag);
        longint acc_e, cnt_e, exp_out;
        mode_sel = sel;
        step_req = STEP_W'(req);
        #2;
        acc_e   = (sel != m_sel) ? 0 : m_acc;
        cnt_e   = (sel != m_sel) ? 0 : m_cnt;
        exp_out = limit_of(acc_e, req, budget_of(sel));
        check(tag, longint'(step_out), exp_out);
        check("R5", longint'(clamp_on), longint'(exp_out != req));
        @(posedge clk);
        m_sel = sel;
        if (cnt_e == window_of(sel) - 1) begin
            m_acc = 0;
            m_cnt = 0;
        end else begin
            m_acc = acc_e + exp_out;
            m_cnt = cnt_e + 1;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired got=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", longint'(step_out), 0);
        check("R8", longint'(clamp_on), 0);
        rst_n = 1'b1;

        // R8: fresh state admits exactly the full 1.5 Hz budget.
        apply(2'b00, 41001, "R8");
        // R1: rest of this short window, then a new one.
        for (int i = 0; i < 12; i++) apply(2'b00, 0, "R6");
        apply(2'b00, 20000, "R1");
        apply(2'b00, 20000, "R1");
        apply(2'b00, 20000, "R4");
        apply(2'b00, 5, "R4");
        apply(2'b00, -90000, "R4");
        for (int i = 0; i < 12; i++) apply(2'b00, 7000, "R6");

        // R7: switch to 6 Hz loop, full new budget, reversal earns allowance.
        apply(2'b11, 60000, "R7");
        apply(2'b11, -100000, "R9");
        apply(2'b11, -1, "R9");
        apply(2'b00, 41000, "R7");
        apply(2'b11, -50000, "R1");

        // R2: 0.1 Hz loop over a full long window.
        for (int i = 0; i < 12; i++) apply(2'b01, 100000, "R2");
        for (longint i = 0; i < WLONG - 13; i++) apply(2'b01, (i % 2 == 0) ? 3 : -3, "R2");
        apply(2'b01, 100000, "R6");
        apply(2'b01, 900000, "R6");

        // R2: 12 Hz loop saturating with the largest steps.
        for (int i = 0; i < 150; i++) apply(2'b10, SMAX, "R2");
        apply(2'b10, -SMAX, "R3");
        apply(2'b10, -SMAX - 1, "R3");

        // R3/R4: seeded random mixture of modes and magnitudes.
        begin
            logic [1:0] rs = 2'b00;
            for (int i = 0; i < 600; i++) begin
                longint lim, v;
                if ($urandom % 16 == 0) rs = 2'($urandom);
                case ($urandom % 4)
                    0: lim = 2000;
                    1: lim = 20000;
                    2: lim = 200000;
                    default: lim = SMAX;
                endcase
                v = longint'($urandom % 32'(2 * lim + 1)) - lim;
                apply(rs, v, "R4");
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule